// File: doc/BRIEF.md
# Request-Paced Single-Word DMA Channel

This block is one DMA channel that moves words from a source location to a destination location, one word for each request raised by a peripheral. A 24-bit control word selects which of 32 request lines paces the channel and which memory space each side uses. It also sets, for each side, whether the address stays fixed or steps by one after every word. Further control bits decide whether the channel drops its enable bit when the run ends, and whether an interrupt is raised. Three more registers hold the source address, the destination address and the transfer count. The count is loaded with the number of words minus one.

A typical pairing uses two instances around a filter coprocessor. A draining channel is paced by "output buffer full" and copies results from a fixed peripheral register into a stepping memory buffer. A feeding channel is paced by "input buffer empty" and copies operands from a stepping buffer into a fixed peripheral register. Each word takes a read cycle and then a write cycle on a simple memory port. Read data returns one cycle after the read strobe. When the last word has been written, the channel raises a one-cycle done pulse and stops accepting requests.

Top module: `dma_req_channel`

## Requirements
- R1: A configuration write (`cfg_we` high at a clock edge) loads the register chosen by `cfg_sel`: 0 the control word, 1 the source address, 2 the destination address, 3 the count. A word run uses these loaded values.
- R2: Control bits [15:11] pick one of the request lines. While the channel is active and idle, that line being high at a clock edge starts a word. `rd_en` is high in the next cycle, and `wr_en` is high in the cycle after that, with `wr_data` equal to the `rd_data` returned for the read.
- R3: `rd_space` shows control bits [1:0] and `wr_space` shows control bits [3:2] (the code 01 denotes Y memory).
- R4: Control bits [6:4] (source) and [9:7] (destination) set the address mode. The code 101 advances that side's address by one after each word. The code 100, and any other code, keeps the address fixed.
- R5: A count of N-1 gives exactly N words. After the write of the last word, `done_o` is high for one cycle, `active_o` falls, and later requests start no word.
- R6: When control bit 22 is set, `irq_o` rises together with `done_o` and stays high until the next control-word write. When bit 22 is clear, `irq_o` stays low.
- R7: `ch_enable` shows control bit 23. If control bits [21:19] are 001, bit 23 is cleared when the run ends. If they are 101, it stays set.
- R8: A control write with bit 23 clear leaves the channel inactive, and requests then start no word. Requests on lines that are not selected, and requests raised while a word is in progress, are also ignored.
- R9: During and after reset, no strobe is driven, and `done_o`, `irq_o`, `ch_enable` and `active_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| cfg_wdata | input | 24 | Configuration write data |
| req_lines | input | 32 | Peripheral request lines |
| rd_en | output | 1 | Read strobe |
| rd_space | output | 2 | Memory space of the read |
| rd_addr | output | 24 | Read address |
| rd_data | input | DATA_W | Read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Write strobe |
| wr_space | output | 2 | Memory space of the write |
| wr_addr | output | 24 | Write address |
| wr_data | output | DATA_W | Write data |
| done_o | output | 1 | One-cycle pulse after the last word |
| irq_o | output | 1 | Done interrupt, sticky until the next control write |
| ch_enable | output | 1 | Current value of control bit 23 |
| active_o | output | 1 | Channel accepts requests |

## Verification
A wrong address register appears on `rd_addr` or `wr_addr` at the very next strobe, and also in the destination memory contents. A count off by one gives an extra or a missing word, and it moves the `done_o` pulse by a whole word, three cycles or more. A sequencer stuck in one phase shows at once as a strobe that stays high or never comes. A bad enable or interrupt flag is visible on `ch_enable`, `irq_o` or `active_o` in the cycle after the last word. A leaking request shows as an unexpected `rd_en` one cycle after the pulse.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int CW      = 24;
  localparam int NUM_REQ = 32;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  localparam logic [2:0] AMODE_INC = 3'b101;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  typedef struct packed {
    logic       en;
    logic       irq_en;
    logic       keep_en;
    logic [4:0] req_sel;
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] dst_space;
    logic [1:0] src_space;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [CW-1:0] w);
    ctrl_t c;
    c.en        = w[23];
    c.irq_en    = w[22];
    c.keep_en   = w[21];
    c.req_sel   = w[15:11];
    c.dst_inc   = (w[9:7] == AMODE_INC);
    c.src_inc   = (w[6:4] == AMODE_INC);
    c.dst_space = w[3:2];
    c.src_space = w[1:0];
    return c;
  endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_nxt;
  logic          addr_ce;

  always_comb begin
    addr_ce  = load | step;
    addr_nxt = load ? load_val : addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_ce) addr_q <= addr_nxt;
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma_word_counter.sv
module dma_word_counter #(
  parameter int CNTW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  input  logic            dec,
  output logic            last
);
  logic [CNTW-1:0] cnt_q, cnt_nxt;
  logic            cnt_ce;

  always_comb begin
    cnt_ce  = load | (dec & (cnt_q != '0));
    cnt_nxt = load ? load_val : cnt_q - CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_nxt;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/dma_word_seq.sv
module dma_word_seq
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic in_read,
  output logic in_write,
  output logic idle
);
  phase_t ph_q, ph_nxt;

  always_comb begin
    ph_nxt = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (start) ph_nxt = PH_READ;
      PH_READ:  ph_nxt = PH_WRITE;
      PH_WRITE: ph_nxt = PH_IDLE;
      default:  ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_nxt;
  end

  assign in_read  = (ph_q == PH_READ);
  assign in_write = (ph_q == PH_WRITE);
  assign idle     = (ph_q == PH_IDLE);
endmodule

// File: rtl/dma_req_channel.sv
module dma_req_channel
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CW-1:0]     cfg_wdata,
  input  logic [NUM_REQ-1:0] req_lines,
  output logic              rd_en,
  output logic [1:0]        rd_space,
  output logic [CW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [1:0]        wr_space,
  output logic [CW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done_o,
  output logic              irq_o,
  output logic              ch_enable,
  output logic              active_o
);
  localparam int NSIDE = 2;

  // reset synchronizer: assert asynchronously, release on clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [CW-1:0] ctrl_q, ctrl_nxt;
  ctrl_t         ctl;
  logic          armed_q, armed_nxt;
  logic          irq_q, irq_nxt;
  logic          done_q, done_nxt;
  logic          ctrl_wr, cnt_wr;
  logic          in_read, in_write, idle, start, req_hit;
  logic          last, run_end;
  logic [NSIDE-1:0]         side_load, side_step;
  logic [NSIDE-1:0][CW-1:0] side_addr;
  logic          unused_bits;

  assign ctl         = decode_ctrl(ctrl_q);
  assign unused_bits = ^{ctrl_q[20:16], ctrl_q[10]};

  assign ctrl_wr = cfg_we & (cfg_sel == SEL_CTRL);
  assign cnt_wr  = cfg_we & (cfg_sel == SEL_CNT);
  assign req_hit = req_lines[ctl.req_sel];
  assign start   = armed_q & idle & req_hit;
  assign run_end = in_write & last;

  // control word, armed flag, interrupt and done pulse
  always_comb begin
    ctrl_nxt  = ctrl_q;
    armed_nxt = armed_q;
    irq_nxt   = irq_q;
    done_nxt  = run_end;
    if (ctrl_wr) begin
      ctrl_nxt  = cfg_wdata;
      armed_nxt = cfg_wdata[23];
      irq_nxt   = 1'b0;
    end else if (run_end) begin
      armed_nxt = 1'b0;
      if (!ctl.keep_en) ctrl_nxt[23] = 1'b0;
      if (ctl.irq_en)   irq_nxt      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nxt;
      armed_q <= armed_nxt;
      irq_q   <= irq_nxt;
      done_q  <= done_nxt;
    end
  end

  // address units: index 0 source, index 1 destination
  genvar gs;
  generate
    for (gs = 0; gs < NSIDE; gs++) begin : g_side
      logic inc_mode;
      assign inc_mode      = (gs == 0) ? ctl.src_inc : ctl.dst_inc;
      assign side_load[gs] = cfg_we & (cfg_sel == ((gs == 0) ? SEL_SRC : SEL_DST));
      assign side_step[gs] = in_write & inc_mode;
      dma_addr_unit #(.AW(CW)) i_addr (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .load     (side_load[gs]),
        .load_val (cfg_wdata),
        .step     (side_step[gs]),
        .addr     (side_addr[gs])
      );
    end
  endgenerate

  dma_word_counter #(.CNTW(CW)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cnt_wr),
    .load_val (cfg_wdata),
    .dec      (in_write),
    .last     (last)
  );

  dma_word_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .in_read  (in_read),
    .in_write (in_write),
    .idle     (idle)
  );

  assign rd_en     = in_read;
  assign rd_space  = ctl.src_space;
  assign rd_addr   = side_addr[0];
  assign wr_en     = in_write;
  assign wr_space  = ctl.dst_space;
  assign wr_addr   = side_addr[1];
  assign wr_data   = rd_data;
  assign done_o    = done_q;
  assign irq_o     = irq_q;
  assign ch_enable = ctrl_q[23];
  assign active_o  = armed_q;
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic rd_en,
  input logic wr_en,
  input logic done_o,
  input logic irq_o,
  input logic ch_enable,
  input logic active_o
);
  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);
  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  assert_read_needs_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> $past(active_o));
  assert_done_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_en));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(cfg_we)) |-> !active_o);
  assert_irq_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> done_o);
  assert_enable_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch_enable) |-> (done_o || $past(cfg_we)));
endmodule

bind dma_req_channel dma_chan_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_we    (cfg_we),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .done_o    (done_o),
  .irq_o     (irq_o),
  .ch_enable (ch_enable),
  .active_o  (active_o)
);

// File: tb/test_dma_req_channel.sv
`timescale 1ns/1ps
module test_dma_req_channel;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [23:0]   cfg_wdata = '0;
  logic [31:0]   req_lines = '0;
  logic          rd_en, wr_en, done_o, irq_o, ch_enable, active_o;
  logic [1:0]    rd_space, wr_space;
  logic [23:0]   rd_addr, wr_addr;
  logic [DW-1:0] rd_data = '0;
  logic [DW-1:0] wr_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int words    = 0;
  bit done_seen = 0;
  logic [DW-1:0] wmem [int];

  always #4 clk = ~clk;

  dma_req_channel #(.DATA_W(DW)) i_dma_req_channel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_lines(req_lines),
    .rd_en(rd_en), .rd_space(rd_space), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_o(done_o), .irq_o(irq_o), .ch_enable(ch_enable), .active_o(active_o)
  );

  function automatic logic [DW-1:0] pat(input logic [1:0] s, input logic [23:0] a);
    return (a * 24'h000131 + {s, 22'h0}) ^ 24'h5A5A5A;
  endfunction

  function automatic int key(input logic [1:0] s, input logic [23:0] a);
    return int'({6'd0, s, a});
  endfunction

  function automatic logic [23:0] mk_ctrl(input bit en, input bit ie, input bit keep,
      input logic [4:0] sel, input logic [2:0] dm, input logic [2:0] sm,
      input logic [1:0] dsp, input logic [1:0] ssp);
    return {en, ie, (keep ? 3'b101 : 3'b001), 2'b11, 1'b0, sel, 1'b0, dm, sm, dsp, ssp};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // memory model
  always @(posedge clk) begin
    cycles++;
    if (rd_en) rd_data <= pat(rd_space, rd_addr);
    if (wr_en) begin
      wmem[key(wr_space, wr_addr)] = wr_data;
      words++;
    end
    if (done_o) done_seen = 1;
  end

  // behavioural reference model, advanced on each rising edge
  int          m_phase = 0;
  bit          m_armed = 0, m_irq = 0, m_done = 0;
  logic [23:0] m_ctrl = '0, m_src = '0, m_dst = '0, m_cnt = '0;

  always @(posedge clk) begin
    bit wend, fin;
    if (!rst_n) begin
      m_phase = 0; m_armed = 0; m_irq = 0; m_done = 0;
      m_ctrl = '0; m_src = '0; m_dst = '0; m_cnt = '0;
    end else begin
      wend = (m_phase == 2);
      fin  = wend && (m_cnt == 0);
      m_done = fin;
      case (m_phase)
        0: if (m_armed && req_lines[m_ctrl[15:11]]) m_phase = 1;
        1: m_phase = 2;
        default: m_phase = 0;
      endcase
      if (wend) begin
        if (m_ctrl[6:4] == 3'b101) m_src = m_src + 1;
        if (m_ctrl[9:7] == 3'b101) m_dst = m_dst + 1;
        if (m_cnt != 0) m_cnt = m_cnt - 1;
      end
      if (cfg_we && cfg_sel == 2'd0) begin
        m_ctrl = cfg_wdata; m_armed = cfg_wdata[23]; m_irq = 0;
      end else if (fin) begin
        m_armed = 0;
        if (m_ctrl[21:19] == 3'b001) m_ctrl[23] = 1'b0;
        if (m_ctrl[22]) m_irq = 1;
      end
      if (cfg_we && cfg_sel == 2'd1) m_src = cfg_wdata;
      if (cfg_we && cfg_sel == 2'd2) m_dst = cfg_wdata;
      if (cfg_we && cfg_sel == 2'd3) m_cnt = cfg_wdata;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    chk(rd_en === (m_phase == 1), "R2 rd_en", rd_en, m_phase == 1);
    chk(wr_en === (m_phase == 2), "R2 wr_en", wr_en, m_phase == 2);
    if (m_phase == 1) begin
      chk(rd_addr === m_src, "R4 rd_addr", rd_addr, m_src);
      chk(rd_space === m_ctrl[1:0], "R3 rd_space", rd_space, m_ctrl[1:0]);
    end
    if (m_phase == 2) begin
      chk(wr_addr === m_dst, "R4 wr_addr", wr_addr, m_dst);
      chk(wr_space === m_ctrl[3:2], "R3 wr_space", wr_space, m_ctrl[3:2]);
      chk(wr_data === pat(m_ctrl[1:0], m_src), "R2 wr_data", wr_data, pat(m_ctrl[1:0], m_src));
    end
    chk(done_o === m_done, "R5 done_o", done_o, m_done);
    chk(active_o === m_armed, "R5 active_o", active_o, m_armed);
    chk(irq_o === m_irq, "R6 irq_o", irq_o, m_irq);
    chk(ch_enable === m_ctrl[23], "R7 ch_enable", ch_enable, m_ctrl[23]);
  end

  task automatic cfg_write(input logic [1:0] s, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int line, input int gap);
    @(negedge clk);
    req_lines[line] = 1'b1;
    @(negedge clk);
    req_lines[line] = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", cycles, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // r9_ reset state
    chk(!rd_en && !wr_en, "R9 strobes in reset", {rd_en, wr_en}, 0);
    chk(!done_o && !irq_o && !ch_enable && !active_o, "R9 flags in reset",
        {done_o, irq_o, ch_enable, active_o}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!active_o && !ch_enable, "R9 flags after reset", {active_o, ch_enable}, 0);

    // feed-like run: source steps, destination fixed, 3 words, keep enable, irq on
    cfg_write(2'd1, 24'h000100);
    cfg_write(2'd2, 24'h000040);
    cfg_write(2'd3, 24'd2);
    cfg_write(2'd0, mk_ctrl(1, 1, 1, 5'd5, 3'b100, 3'b101, 2'b01, 2'b00));
    words = 0; done_seen = 0;
    pulse(5, 5);
    chk(words == 1, "R1 first word", words, 1);
    chk(wmem.exists(key(2'b01, 24'h40)) && wmem[key(2'b01, 24'h40)] == pat(2'b00, 24'h100),
        "R1 first word source", wmem[key(2'b01, 24'h40)], pat(2'b00, 24'h100));
    pulse(3, 5);                                 // unselected line
    chk(words == 1, "R8 unselected line", words, 1);
    pulse(5, 5);
    pulse(5, 5);
    chk(words == 3, "R5 three words", words, 3);
    chk(done_seen, "R5 done seen", done_seen, 1);
    chk(irq_o === 1'b1, "R6 irq set", irq_o, 1);
    chk(ch_enable === 1'b1, "R7 enable kept", ch_enable, 1);
    chk(wmem[key(2'b01, 24'h40)] == pat(2'b00, 24'h102), "R4 fixed destination",
        wmem[key(2'b01, 24'h40)], pat(2'b00, 24'h102));
    pulse(5, 5);
    chk(words == 3, "R5 request after done", words, 3);

    // drain-like run: source fixed, destination steps, 2 words, clear enable, irq off
    cfg_write(2'd1, 24'h000020);
    cfg_write(2'd2, 24'h000080);
    cfg_write(2'd3, 24'd1);
    cfg_write(2'd0, mk_ctrl(1, 0, 0, 5'd22, 3'b101, 3'b100, 2'b01, 2'b01));
    chk(irq_o === 1'b0, "R6 irq cleared by control write", irq_o, 0);
    words = 0;
    @(negedge clk);
    req_lines[22] = 1'b1;                        // held high: words back to back
    repeat (20) @(negedge clk);
    req_lines[22] = 1'b0;
    chk(words == 2, "R5 two words held request", words, 2);
    chk(ch_enable === 1'b0, "R7 enable cleared", ch_enable, 0);
    chk(irq_o === 1'b0, "R6 irq masked", irq_o, 0);
    chk(wmem[key(2'b01, 24'h80)] == pat(2'b01, 24'h20) &&
        wmem[key(2'b01, 24'h81)] == pat(2'b01, 24'h20), "R4 stepping destination",
        wmem[key(2'b01, 24'h81)], pat(2'b01, 24'h20));
    chk(!wmem.exists(key(2'b01, 24'h82)), "R5 no extra word", 1, 0);

    // disabled channel
    cfg_write(2'd3, 24'd3);
    cfg_write(2'd0, mk_ctrl(0, 1, 1, 5'd5, 3'b101, 3'b101, 2'b01, 2'b01));
    words = 0;
    pulse(5, 3);
    pulse(5, 3);
    chk(words == 0, "R8 disabled ignores request", words, 0);
    chk(active_o === 1'b0, "R8 inactive", active_o, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule